// File: doc/BRIEF.md
# Selectable Clock Divider with Gated Eight-Lane Fanout

This block takes one reference clock waveform, divides its frequency by 1, 2, 4 or 8, and copies the result onto a set of output lanes. A 2-bit select input chooses the ratio. The select and the per-lane disable mask both come from logic that does not share the reference clock's timing. The block synchronises both before it uses them, and it applies every change at a point where the change cannot produce a short pulse on any lane.

The reference waveform arrives as a level on `ref_i`. It is sampled by the fabric clock `clk_i`, which must run at least four times faster than the reference. Each lane has a disable bit. A bit at 1 puts that lane into high-impedance, and a bit at 0 lets the lane drive the divided clock. The high-impedance state is modelled as a tri-state output plus a separate "driving" flag for each lane. After reset every lane is off, and the active ratio is divide-by-1.

Top module: `clkfan_top`

## Requirements
- R1: The select codes map to ratios as follows: 00 gives divide-by-1, 01 gives divide-by-2, 10 gives divide-by-4 and 11 gives divide-by-8. With a reference period of 8 `clk_i` cycles, a 512-cycle window therefore holds 64, 32, 16 or 8 rising edges.
- R2: After reset the active ratio is divide-by-1. With the select held at 00, an enabled lane follows the reference frequency without any prior select write.
- R3: All lanes that are driving carry the same waveform in every cycle.
- R4: A disable bit of 0 makes its lane drive (`lane_drv_o` bit = 1). A disable bit of 1 floats its lane (`lane_o` bit = z, `lane_drv_o` bit = 0). Bit n of `lane_off_i` controls lane n.
- R5: While reset is asserted, and after reset until a disable bit is cleared, every lane is floating and every driving flag is 0.
- R6: In divide-by-2, divide-by-4 and divide-by-8, the high and low times of a lane are equal. In divide-by-1 they follow the reference: a reference that is high for 3 cycles and low for 5 cycles gives a lane that is high for 3 cycles and low for 5 cycles.
- R7: A lane starts or stops driving only while the divided clock is low, so every high pulse it shows is a full half-period.
- R8: A new select value takes effect only when the 3-bit ratio counter wraps from 7 to 0. Switching among divide-by-2, divide-by-4 and divide-by-8 therefore never shows a high pulse other than 8, 16 or 32 cycles long (with a reference period of 8 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock that samples the reference and runs all logic |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock waveform, asynchronous to `clk_i` |
| div_sel_i | input | 2 | Ratio select, asynchronous |
| lane_off_i | input | 8 | Per-lane disable mask, 1 = high-impedance, asynchronous |
| lane_o | output | 8 | Divided clock per lane, z when disabled |
| lane_drv_o | output | 8 | Per-lane flag, 1 when the lane is driving |

## Verification
The reference is driven with an uneven 3-high, 5-low shape, so divide-by-1 can be told apart from the even-duty ratios by its pulse widths as well as by its edge count. Each select code is held steady and measured for edge count, high time and low time; this separates the four ratios and shows that the duty cycle evens out above divide-by-1. One lane is enabled and disabled at offsets that drift against the divide-by-8 period, so that the requests land in both the high and the low half. A separate phase hops among the three even ratios and checks that every high pulse keeps a legal width across each switch. A sparse mask pattern confirms that each mask bit reaches only its own lane.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_CNT_W  = 3;
  localparam int unsigned DEF_STAGES = 2;

  // Select width needed to address divide-by-1 plus one ratio per counter bit.
  function automatic int unsigned sel_width(input int unsigned cnt_w);
    return $clog2(cnt_w + 1);
  endfunction
endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkfan_divider.sv
module clkfan_divider #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ref_s_i,
  input  logic [SEL_W-1:0] sel_s_i,
  output logic             div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SEL_W-1:0] sel_act_o
);
  logic             ref_d;
  logic             rise;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_use;
  logic             div_q;
  logic             div_nxt;

  assign rise    = ref_s_i & ~ref_d;
  assign cnt_nxt = cnt_q + CNT_W'(rise);
  assign wrap    = rise && (cnt_q == '1);
  assign sel_use = wrap ? sel_s_i : sel_q;

  // Code 0 passes the reference level; code k picks counter bit k-1.
  always_comb begin
    div_nxt = ref_s_i;
    for (int k = 1; k <= CNT_W; k++) begin
      if (sel_use == SEL_W'(k)) div_nxt = cnt_nxt[k-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ref_d <= 1'b0;
      cnt_q <= '0;
      sel_q <= '0;
      div_q <= 1'b0;
    end else begin
      ref_d <= ref_s_i;
      cnt_q <= cnt_nxt;
      if (wrap) sel_q <= sel_s_i;
      div_q <= div_nxt;
    end
  end

  assign div_o     = div_q;
  assign cnt_o     = cnt_q;
  assign sel_act_o = sel_q;
endmodule

// File: rtl/clkfan_lane.sv
module clkfan_lane (
  input  logic clk_i,
  input  logic rst_i,
  input  logic off_s_i,
  input  logic div_i,
  output logic val_o,
  output logic drv_o
);
  logic off_q;

  // The gate state may only move while the shared divided clock is low.
  always_ff @(posedge clk_i) begin
    if (rst_i)       off_q <= 1'b1;
    else if (!div_i) off_q <= off_s_i;
  end

  assign val_o = div_i & ~off_q;
  assign drv_o = ~off_q;
endmodule

// File: rtl/clkfan_top.sv
module clkfan_top #(
  parameter int unsigned LANES  = clkfan_pkg::DEF_LANES,
  parameter int unsigned CNT_W  = clkfan_pkg::DEF_CNT_W,
  parameter int unsigned STAGES = clkfan_pkg::DEF_STAGES,
  localparam int unsigned SEL_W = clkfan_pkg::sel_width(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ref_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [LANES-1:0] lane_off_i,
  output logic [LANES-1:0] lane_o,
  output logic [LANES-1:0] lane_drv_o
);
  logic             ref_s;
  logic [SEL_W-1:0] sel_s;
  logic [LANES-1:0] off_s;
  logic             div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_act;
  logic [LANES-1:0] lane_val;

  clkfan_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_ref_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(ref_i), .q_o(ref_s)
  );

  clkfan_sync #(.W(SEL_W), .STAGES(STAGES), .RST_VAL('0)) u_sel_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(div_sel_i), .q_o(sel_s)
  );

  clkfan_sync #(.W(LANES), .STAGES(STAGES), .RST_VAL('1)) u_off_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(lane_off_i), .q_o(off_s)
  );

  clkfan_divider #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .ref_s_i(ref_s), .sel_s_i(sel_s),
    .div_o(div_q), .cnt_o(cnt_q), .sel_act_o(sel_act)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    clkfan_lane u_lane (
      .clk_i(clk_i), .rst_i(rst_i), .off_s_i(off_s[g]), .div_i(div_q),
      .val_o(lane_val[g]), .drv_o(lane_drv_o[g])
    );
    assign lane_o[g] = lane_drv_o[g] ? lane_val[g] : 1'bz;
  end
endmodule

// File: rtl/clkfan_checker.sv
module clkfan_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             div_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [SEL_W-1:0] sel_act_i,
  input logic [LANES-1:0] lane_o,
  input logic [LANES-1:0] lane_drv_o
);
  // R5: one cycle of reset leaves every lane off
  a_r5_reset_all_off: assert property (@(posedge clk_i)
    rst_i |=> (lane_drv_o == '0));

  // R2: reset restores divide-by-1
  a_r2_reset_ratio: assert property (@(posedge clk_i)
    rst_i |=> (sel_act_i == '0));

  // R3: every driving lane matches the shared divided clock
  a_r3_lanes_agree: assert property (@(posedge clk_i) disable iff (rst_i)
    (((lane_o ^ {LANES{div_i}}) & lane_drv_o) == '0));

  // R7: gate flags move only when the divided clock was low
  a_r7_gate_when_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (lane_drv_o != $past(lane_drv_o)) |-> !$past(div_i));

  // R8: the active ratio changes only on a counter wrap
  a_r8_sel_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_act_i != $past(sel_act_i)) |-> ((cnt_i == '0) && ($past(cnt_i) == '1)));
endmodule

bind clkfan_top clkfan_checker #(.LANES(LANES), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .div_i(div_q), .cnt_i(cnt_q),
  .sel_act_i(sel_act), .lane_o(lane_o), .lane_drv_o(lane_drv_o)
);

// File: tb/test_clkfan_top.sv
`timescale 1ns/1ps
module test_clkfan_top;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       ref_i = 1'b0;
  logic [1:0] div_sel_i = 2'b00;
  logic [7:0] lane_off_i = 8'hFF;
  wire  [7:0] lane_o;
  wire  [7:0] lane_drv_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clkfan_top i_clkfan_top (
    .clk_i(clk), .rst_i(rst_i), .ref_i(ref_i), .div_sel_i(div_sel_i),
    .lane_off_i(lane_off_i), .lane_o(lane_o), .lane_drv_o(lane_drv_o)
  );

  // Reference: 3 cycles high, 5 cycles low, changed just after posedge.
  initial begin
    #2;
    forever begin
      ref_i = 1'b1; repeat (3) @(posedge clk); #2;
      ref_i = 1'b0; repeat (5) @(posedge clk); #2;
    end
  end

  // Monitors sample on the falling edge.
  bit mon_clr = 1'b0;
  bit prev0, first0, prev1;
  int run0, rises0, hi0, lo0, odd0, pulses0;
  int run1, pulses1, bad1, mism;

  always @(negedge clk) begin
    automatic bit l0 = (lane_o[0] === 1'b1);
    automatic bit l1 = (lane_o[1] === 1'b1);
    for (int i = 1; i < 8; i++)
      if (lane_drv_o[0] && lane_drv_o[i] && (lane_o[i] !== lane_o[0])) mism++;
    if (mon_clr) begin
      prev0 = l0; first0 = 1'b1; run0 = 1; rises0 = 0; hi0 = 0; lo0 = 0;
      odd0 = 0; pulses0 = 0; prev1 = l1; run1 = 1; pulses1 = 0; bad1 = 0; mism = 0;
    end else begin
      if (l0 == prev0) run0++;
      else begin
        if (!first0) begin
          if (prev0) begin
            hi0 = run0; pulses0++;
            if (!(run0 inside {3, 8, 16, 32})) odd0++;
          end else lo0 = run0;
        end
        first0 = 1'b0; run0 = 1;
        if (l0) rises0++;
        prev0 = l0;
      end
      if (l1 == prev1) run1++;
      else begin
        if (prev1) begin
          pulses1++;
          if (run1 != 32) bad1++;
        end
        run1 = 1; prev1 = l1;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; wait_cyc(1); mon_clr = 1'b0;
  endtask

  // Each entry: select, rising edges in 512 cycles, high time, low time.
  localparam logic [25:0] VEC [4] = '{
    {2'b01, 8'd32, 8'd8,  8'd8},
    {2'b10, 8'd16, 8'd16, 8'd16},
    {2'b11, 8'd8,  8'd32, 8'd32},
    {2'b00, 8'd64, 8'd3,  8'd5}
  };

  task automatic measure(input int e_edges, input int e_hi, input int e_lo, input string tag);
    clear_mon();
    wait_cyc(512);
    check(rises0 == e_edges, {tag, " R1 edge count"}, rises0, e_edges);
    check(hi0 == e_hi, {tag, " R6 high time"}, hi0, e_hi);
    check(lo0 == e_lo, {tag, " R6 low time"}, lo0, e_lo);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    wait_cyc(6);
    // R5: during reset nothing drives
    check(lane_drv_o == 8'h00, "R5 drive flags in reset", lane_drv_o, 0);
    rst_i = 1'b0;
    wait_cyc(30);
    check(lane_drv_o == 8'h00, "R5 drive flags after reset", lane_drv_o, 0);
    check(lane_o[0] === 1'bz, "R5 lane0 floats after reset", lane_o[0], 0);

    // R2: default ratio is divide-by-1 with no select written
    lane_off_i = 8'h00;
    wait_cyc(100);
    measure(64, 3, 5, "R2 default");

    // R1/R6: table of ratios; R3 lanes agree across all of it
    clear_mon();
    for (int v = 0; v < 4; v++) begin
      div_sel_i = VEC[v][25:24];
      wait_cyc(120);
      measure(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), "table");
    end
    check(mism == 0, "R3 lane mismatch cycles", mism, 0);

    // R4: sparse mask
    lane_off_i = 8'b1010_0110;
    wait_cyc(40);
    check(lane_drv_o == 8'b0101_1001, "R4 drive flags", lane_drv_o, 8'b0101_1001);
    check(lane_o[1] === 1'bz, "R4 lane1 floats", lane_o[1], 0);
    check(lane_o[0] !== 1'bz, "R4 lane0 drives", lane_o[0], 1);

    // R7: toggle lane1 at drifting offsets in divide-by-8
    div_sel_i = 2'b11;
    lane_off_i = 8'hFE;
    wait_cyc(150);
    clear_mon();
    for (int k = 0; k < 10; k++) begin
      lane_off_i[1] = 1'b0; wait_cyc(25 + k * 9);
      lane_off_i[1] = 1'b1; wait_cyc(30 + k * 7);
    end
    wait_cyc(80);
    check(bad1 == 0, "R7 short pulses on lane1", bad1, 0);
    check(pulses1 >= 3, "R7 lane1 pulses seen", pulses1, 3);
    check(lane_drv_o[1] == 1'b0, "R7 lane1 off at end", lane_drv_o[1], 0);

    // R8: hop among even ratios
    lane_off_i = 8'h00;
    div_sel_i = 2'b01;
    wait_cyc(150);
    clear_mon();
    begin
      automatic logic [1:0] hops [6] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b01, 2'b10};
      for (int k = 0; k < 6; k++) begin
        div_sel_i = hops[k];
        wait_cyc(100 + k * 23);
      end
    end
    check(odd0 == 0, "R8 odd pulse widths", odd0, 0);
    check(pulses0 > 10, "R8 pulses seen", pulses0, 11);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
      $finish;
    end
  end
endmodule